// File: doc/BRIEF.md
# Tiled View Address Generator

This block maps a pixel coordinate inside a two-dimensional tiled container to a 32-bit address in tiled space. Each request carries an element format, a view orientation and an X/Y coordinate. The block checks the coordinate against the range that the format allows. It then applies mirroring and X/Y transposition, scales the linear offset by the format's element shift, and places the orientation and format tags in the top address bits. Alongside the address it returns the line stride for the chosen view.

The block has one register stage. A request presented with `valid_i` high is captured on the rising clock edge, and its result appears with `valid_o` high one cycle after the request. When no request is present the outputs keep their last result. A coordinate outside the allowed range yields address zero.

The container dimensions are parameters: `CONT_W_BITS` and `CONT_H_BITS` give the bit counts of the container width and height, and `SLOT_W_BITS` and `SLOT_H_BITS` give the slot dimensions used by page format. With the defaults (14, 13, 6, 6) the offset fills address bits [26:0].

Top module: `tiler_view_addr`

## Requirements
- R1: While `rst_ni` is low, and until the first request after reset, `valid_o`, `addr_o` and `stride_o` are all zero.
- R2: `valid_o` is high in the cycle after a cycle in which `valid_i` was high, and low otherwise. `addr_o` and `stride_o` are loaded only from a valid request and otherwise hold their value.
- R3: For an in-range request, `addr_o[28:27]` carries the format code: 0 is 8-bit, 1 is 16-bit, 2 is 32-bit, 3 is page.
- R4: For an in-range request, `addr_o[31:29]` equals `orient_i`. Orientation bit 0 inverts X, bit 1 inverts Y, and bit 2 swaps X and Y.
- R5: Each format has an X shift and a Y shift: 8-bit (0,0), 16-bit (0,1), 32-bit (1,1), page (`SLOT_W_BITS`,`SLOT_H_BITS`). The linear offset is shifted left by the sum of the two shifts before it is placed in `addr_o[26:0]`.
- R6: The usable X width is `CONT_W_BITS` minus the X shift, and the usable Y width is `CONT_H_BITS` minus the Y shift. If either coordinate exceeds the all-ones mask of its width, `addr_o` is zero (including the tag bits).
- R7: When X inversion is set, X is XORed with its full mask before it is used. When Y inversion is set, Y is XORed with its full mask.
- R8: With no swap the offset is (Y << x_width) + X. With swap it is (X << y_width) + Y. Both use the coordinates after mirroring.
- R9: `stride_o` is 1 << (`CONT_H_BITS` + X shift) when swap is set, and 1 << (`CONT_W_BITS` + Y shift) otherwise. The stride does not depend on whether the coordinate is in range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Request present |
| fmt_i | input | 2 | Element format code |
| orient_i | input | 3 | View orientation (bit 0 X invert, bit 1 Y invert, bit 2 swap) |
| x_i | input | COORD_W | X coordinate |
| y_i | input | COORD_W | Y coordinate |
| valid_o | output | 1 | Result present |
| addr_o | output | 32 | Tiled-space address |
| stride_o | output | 32 | Line stride for the view |

## Verification
The vector table covers every format with the identity view, so the four shift pairs and format tags can be told apart. It also covers each orientation bit used alone and all three together, so mirroring can be told apart from transposition and a swapped X/Y role would show up. Coordinates at the top of each format's range are paired with coordinates one step past it, which separates an off-by-one mask from a correct one and shows that the stride still follows the view when the address is zeroed. Directed steps check the reset values and check that the outputs hold when inputs change without a request.

// File: rtl/tiler_addr_pkg.sv
`timescale 1ns/1ps
package tiler_addr_pkg;
  typedef enum logic [1:0] {
    FMT_8B   = 2'd0,
    FMT_16B  = 2'd1,
    FMT_32B  = 2'd2,
    FMT_PAGE = 2'd3
  } elem_fmt_e;

  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned FMT_W    = 2;
  localparam int unsigned ORIENT_W = 3;
  localparam int unsigned OFF_W    = ADDR_W - FMT_W - ORIENT_W;
  localparam int unsigned SH_W     = 5;
  localparam int unsigned BITS_W   = 6;

  localparam int unsigned OR_XINV = 0;
  localparam int unsigned OR_YINV = 1;
  localparam int unsigned OR_SWAP = 2;
endpackage

// File: rtl/tiler_fmt_geom.sv
`timescale 1ns/1ps
module tiler_fmt_geom
  import tiler_addr_pkg::*;
#(
  parameter int unsigned SLOT_W_BITS = 6,
  parameter int unsigned SLOT_H_BITS = 6
) (
  input  logic [FMT_W-1:0] fmt_i,
  output logic [SH_W-1:0]  x_shift_o,
  output logic [SH_W-1:0]  y_shift_o
);
  always_comb begin
    unique case (elem_fmt_e'(fmt_i))
      FMT_8B:   begin x_shift_o = SH_W'(0); y_shift_o = SH_W'(0); end
      FMT_16B:  begin x_shift_o = SH_W'(0); y_shift_o = SH_W'(1); end
      FMT_32B:  begin x_shift_o = SH_W'(1); y_shift_o = SH_W'(1); end
      default:  begin x_shift_o = SH_W'(SLOT_W_BITS); y_shift_o = SH_W'(SLOT_H_BITS); end
    endcase
  end
endmodule

// File: rtl/tiler_coord_map.sv
`timescale 1ns/1ps
module tiler_coord_map
  import tiler_addr_pkg::*;
#(
  parameter int unsigned CONT_W_BITS = 14,
  parameter int unsigned CONT_H_BITS = 13,
  parameter int unsigned COORD_W     = 16
) (
  input  logic [ORIENT_W-1:0] orient_i,
  input  logic [COORD_W-1:0]  x_i,
  input  logic [COORD_W-1:0]  y_i,
  input  logic [SH_W-1:0]     x_shift_i,
  input  logic [SH_W-1:0]     y_shift_i,
  output logic                in_range_o,
  output logic [OFF_W-1:0]    off_o
);
  logic [BITS_W-1:0]  x_bits, y_bits, elem_sh;
  logic [COORD_W-1:0] x_mask, y_mask, xm, ym;
  logic [OFF_W-1:0]   lin;

  assign x_bits  = BITS_W'(CONT_W_BITS) - BITS_W'(x_shift_i);
  assign y_bits  = BITS_W'(CONT_H_BITS) - BITS_W'(y_shift_i);
  assign elem_sh = BITS_W'(x_shift_i) + BITS_W'(y_shift_i);

  // a width equal to COORD_W wraps to an all-ones mask
  assign x_mask = (COORD_W'(1) << x_bits) - COORD_W'(1);
  assign y_mask = (COORD_W'(1) << y_bits) - COORD_W'(1);

  assign in_range_o = (x_i <= x_mask) && (y_i <= y_mask);

  assign xm = orient_i[OR_XINV] ? (x_i ^ x_mask) : x_i;
  assign ym = orient_i[OR_YINV] ? (y_i ^ y_mask) : y_i;

  always_comb begin
    if (orient_i[OR_SWAP]) lin = (OFF_W'(xm) << y_bits) + OFF_W'(ym);
    else                   lin = (OFF_W'(ym) << x_bits) + OFF_W'(xm);
  end

  assign off_o = lin << elem_sh;
endmodule

// File: rtl/tiler_stride_gen.sv
`timescale 1ns/1ps
module tiler_stride_gen
  import tiler_addr_pkg::*;
#(
  parameter int unsigned CONT_W_BITS = 14,
  parameter int unsigned CONT_H_BITS = 13
) (
  input  logic                swap_i,
  input  logic [SH_W-1:0]     x_shift_i,
  input  logic [SH_W-1:0]     y_shift_i,
  output logic [ADDR_W-1:0]   stride_o
);
  logic [BITS_W-1:0] exp_sh;

  assign exp_sh   = swap_i ? BITS_W'(CONT_H_BITS) + BITS_W'(x_shift_i)
                           : BITS_W'(CONT_W_BITS) + BITS_W'(y_shift_i);
  assign stride_o = ADDR_W'(1) << exp_sh;
endmodule

// File: rtl/tiler_view_addr.sv
`timescale 1ns/1ps
module tiler_view_addr
  import tiler_addr_pkg::*;
#(
  parameter int unsigned CONT_W_BITS = 14,
  parameter int unsigned CONT_H_BITS = 13,
  parameter int unsigned SLOT_W_BITS = 6,
  parameter int unsigned SLOT_H_BITS = 6,
  parameter int unsigned COORD_W     = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [1:0]          fmt_i,
  input  logic [2:0]          orient_i,
  input  logic [COORD_W-1:0]  x_i,
  input  logic [COORD_W-1:0]  y_i,
  output logic                valid_o,
  output logic [31:0]         addr_o,
  output logic [31:0]         stride_o
);
  logic [SH_W-1:0]   x_shift, y_shift;
  logic              in_range;
  logic [OFF_W-1:0]  off;
  logic [ADDR_W-1:0] addr_d, stride_d;

  tiler_fmt_geom #(
    .SLOT_W_BITS(SLOT_W_BITS),
    .SLOT_H_BITS(SLOT_H_BITS)
  ) i_geom (
    .fmt_i     (fmt_i),
    .x_shift_o (x_shift),
    .y_shift_o (y_shift)
  );

  tiler_coord_map #(
    .CONT_W_BITS(CONT_W_BITS),
    .CONT_H_BITS(CONT_H_BITS),
    .COORD_W    (COORD_W)
  ) i_coord (
    .orient_i  (orient_i),
    .x_i       (x_i),
    .y_i       (y_i),
    .x_shift_i (x_shift),
    .y_shift_i (y_shift),
    .in_range_o(in_range),
    .off_o     (off)
  );

  tiler_stride_gen #(
    .CONT_W_BITS(CONT_W_BITS),
    .CONT_H_BITS(CONT_H_BITS)
  ) i_stride (
    .swap_i    (orient_i[OR_SWAP]),
    .x_shift_i (x_shift),
    .y_shift_i (y_shift),
    .stride_o  (stride_d)
  );

  assign addr_d = in_range ? {orient_i, fmt_i, off} : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      addr_o   <= '0;
      stride_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        addr_o   <= addr_d;
        stride_o <= stride_d;
      end
    end
  end

  // R2
  p_valid_follow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && $stable(addr_o) && $stable(stride_o));
  // R6
  p_range_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !in_range) |=> addr_o == '0);
  // R3
  p_fmt_tag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && in_range) |=> addr_o[28:27] == $past(fmt_i));
  // R4
  p_view_tag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && in_range) |=> addr_o[31:29] == $past(orient_i));
  // R9
  p_stride_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $countones(stride_o) == 1);
endmodule

// File: tb/test_tiler_view_addr.sv
`timescale 1ns/1ps
module test_tiler_view_addr;
  localparam int COORD_W = 16;
  localparam int NVEC    = 12;

  typedef struct packed {
    logic [1:0]  fmt;
    logic [2:0]  orient;
    logic [15:0] x;
    logic [15:0] y;
    logic [31:0] addr;
    logic [31:0] stride;
  } vec_t;

  // fmt, orient, x, y, expected addr, expected stride
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 3'd0, 16'h0005, 16'h0003, 32'h0000C005, 32'h00004000}, // 8-bit identity
    '{2'd1, 3'd0, 16'h0010, 16'h0002, 32'h08010020, 32'h00008000}, // 16-bit shift
    '{2'd2, 3'd4, 16'h0001, 16'h0002, 32'h90004008, 32'h00004000}, // 32-bit swap
    '{2'd0, 3'd1, 16'h0000, 16'h0000, 32'h20003FFF, 32'h00004000}, // X invert
    '{2'd0, 3'd2, 16'h0001, 16'h0000, 32'h47FFC001, 32'h00004000}, // Y invert
    '{2'd3, 3'd0, 16'h0012, 16'h0003, 32'h18312000, 32'h00100000}, // page identity
    '{2'd3, 3'd7, 16'h0012, 16'h0003, 32'hFF6FC000, 32'h00080000}, // page all bits
    '{2'd0, 3'd0, 16'h3FFF, 16'h1FFF, 32'h07FFFFFF, 32'h00004000}, // 8-bit max
    '{2'd0, 3'd0, 16'h4000, 16'h0000, 32'h00000000, 32'h00004000}, // X past range
    '{2'd2, 3'd5, 16'h0000, 16'h1000, 32'h00000000, 32'h00004000}, // Y past range
    '{2'd1, 3'd0, 16'h0000, 16'h0FFF, 32'h0FFF8000, 32'h00008000}, // 16-bit Y max
    '{2'd3, 3'd0, 16'h0100, 16'h0000, 32'h00000000, 32'h00100000}  // page X past
  };

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic               valid_i = 1'b0;
  logic [1:0]         fmt_i = '0;
  logic [2:0]         orient_i = '0;
  logic [COORD_W-1:0] x_i = '0;
  logic [COORD_W-1:0] y_i = '0;
  logic               valid_o;
  logic [31:0]        addr_o;
  logic [31:0]        stride_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  tiler_view_addr i_tiler_view_addr (
    .clk_i, .rst_ni, .valid_i, .fmt_i, .orient_i, .x_i, .y_i,
    .valid_o, .addr_o, .stride_o
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk_i);
    valid_i  = 1'b1;
    fmt_i    = v.fmt;
    orient_i = v.orient;
    x_i      = v.x;
    y_i      = v.y;
    @(posedge clk_i);
    #1;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    check("R1 valid_o in reset", {31'b0, valid_o}, 32'd0);
    check("R1 addr_o in reset", addr_o, 32'd0);
    check("R1 stride_o in reset", stride_o, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i);
    #1;
    check("R1 outputs idle after release", addr_o | stride_o | {31'b0, valid_o}, 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      apply(VECS[i]);
      check($sformatf("R2 valid_o vec%0d", i), {31'b0, valid_o}, 32'd1);
      check($sformatf("R3 R4 R5 R6 R7 R8 addr vec%0d", i), addr_o, VECS[i].addr);
      check($sformatf("R9 stride vec%0d", i), stride_o, VECS[i].stride);
    end

    // R2: inputs change with no request; outputs hold last result
    @(negedge clk_i);
    valid_i  = 1'b0;
    fmt_i    = 2'd2;
    orient_i = 3'd7;
    x_i      = 16'h0001;
    y_i      = 16'h0001;
    @(posedge clk_i);
    #1;
    check("R2 valid_o drops", {31'b0, valid_o}, 32'd0);
    check("R2 addr_o holds", addr_o, VECS[NVEC-1].addr);
    check("R2 stride_o holds", stride_o, VECS[NVEC-1].stride);
    @(posedge clk_i);
    #1;
    check("R2 addr_o still holds", addr_o, VECS[NVEC-1].addr);

    // R9: stride follows view for 32-bit swap at X max (x=0x1FFF, y=0)
    apply('{2'd2, 3'd4, 16'h1FFF, 16'h0000, 32'h97FFC000, 32'h00004000});
    check("R8 R5 addr 32-bit swap X max", addr_o, 32'h97FFC000);
    check("R9 stride 32-bit swap", stride_o, 32'h00004000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule